// File: doc/BRIEF.md
# Cascadable Dual 8-bit Compare Timer

The block holds two up-counters, each paired with its own compare register. Both counters advance on a shared count-clock input. When a counter's value equals its compare register on a count event, the counter returns to zero and raises a one-cycle interrupt pulse. A counter run this way is an interval timer whose period is the compare value plus one.

A cascade bit joins the two counters into one wider timer. The high counter then advances once each time the low counter wraps. Only the high interrupt can fire, and it fires only when both halves match their compare values on the same event. A separate mode field turns the low output into a PWM signal. In that mode the low compare register sets the period and a high-width register sets how long the output stays high. The block flags compare values that are illegal for the selected count edge.

Output-enable bits hold each timer output low. With the enable cleared, the compare register can be rewritten during PWM without a stray pulse reaching the pin. All state is written through a small register port.

Top module: `cmp_timer_pair`

## Requirements
- R1: Outside cascade, on a count event with the low counter equal to the low compare register, the counter clears to 0 and `irq_lo` pulses for one cycle. On other events the counter increments.
- R2: Register 3 bit 2 selects the count edge. When it is 0, only rising edges of `cnt_in` are count events. When it is 1, both edges are count events.
- R3: While cascade (register 3 bit 3) is set, `irq_lo` stays low.
- R4: In cascade, the high counter increments once per low-counter wrap. `irq_hi` pulses only when both counters equal their compare registers on the same event, and both counters then clear. Outside cascade, the high counter behaves as R1 does, using `irq_hi`.
- R5: When the mode field (register 3 bits 1:0) is 2'b10 and cascade is clear, `out_lo` is high while the low count is below the high-width register (address 2) and low from there until the period match.
- R6: `cfg_err` is high in PWM mode when the low compare value is illegal. With rising-edge counting, 00h is illegal. With both-edge counting, 00h, 01h and FFh are illegal.
- R7: With the output enable of a channel cleared (register 3 bit 4 for low, bit 5 for high), that output is low and its toggle state clears. This holds even while the compare register is rewritten during PWM.
- R8: Outside PWM, `out_lo` toggles on each `irq_lo` event and `out_hi` toggles on each `irq_hi` event, while the channel's output is enabled.
- R9: After reset, both counters, both outputs, both interrupts, `cfg_err` and all registers are 0.
- R10: A write with `wr_en` high stores `wr_data` at `wr_addr`: 0 is the low compare, 1 is the high compare, 2 is the high width and 3 is control. The new value applies from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | W (8) | Write data |
| cnt_in | input | 1 | Count-clock level, sampled on clk |
| out_lo | output | 1 | Low timer output (toggle or PWM) |
| out_hi | output | 1 | High timer output (toggle) |
| irq_lo | output | 1 | Low match interrupt pulse |
| irq_hi | output | 1 | High / joint match interrupt pulse |
| cfg_err | output | 1 | Illegal PWM compare setting |

## Verification
A level change on `cnt_in` is sampled at one rising edge, and the counters update at that same edge. The interrupt pulses are registered at that edge, so they appear one cycle after the input is driven. `out_lo`, `out_hi` and `cfg_err` are decoded from registers, so they follow a register write or count event right after the edge that captures it. The bench drives inputs at the falling edge. At the next falling edge it compares every output with a cycle model, which it advances on the same rising edges from the stimulus alone.

// File: rtl/ctp_pkg.sv
package ctp_pkg;

   typedef enum logic [1:0] {
      MODE_INTERVAL = 2'b00,
      MODE_RSVD_A   = 2'b01,
      MODE_PWM      = 2'b10,
      MODE_RSVD_B   = 2'b11
   } ctp_mode_e;

   // packed: oe_hi is bit 5, mode occupies bits 1:0
   typedef struct packed {
      logic      oe_hi;
      logic      oe_lo;
      logic      cascade;
      logic      both_edges;
      ctp_mode_e mode;
   } ctp_ctrl_t;

   localparam int unsigned CTRL_BITS = $bits(ctp_ctrl_t);
   localparam int unsigned ADDR_W    = 2;
   localparam int unsigned NUM_CH    = 2;

   localparam logic [ADDR_W-1:0] A_CMP_LO = 2'd0;
   localparam logic [ADDR_W-1:0] A_CMP_HI = 2'd1;
   localparam logic [ADDR_W-1:0] A_HWID   = 2'd2;
   localparam logic [ADDR_W-1:0] A_CTRL   = 2'd3;

endpackage

// File: rtl/ctp_regs.sv
module ctp_regs
   import ctp_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [W-1:0]      wr_data,
   output logic [W-1:0]      cmp_lo,
   output logic [W-1:0]      cmp_hi,
   output logic [W-1:0]      hwid,
   output ctp_ctrl_t         ctrl
);

   if (W < CTRL_BITS) begin : g_bad_width
      $error("ctp_regs: W must hold the control field");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_lo <= '0;
         cmp_hi <= '0;
         hwid   <= '0;
         ctrl   <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_CMP_LO: cmp_lo <= wr_data;
            A_CMP_HI: cmp_hi <= wr_data;
            A_HWID:   hwid   <= wr_data;
            default:  ctrl   <= ctp_ctrl_t'(wr_data[CTRL_BITS-1:0]);
         endcase
      end
   end

endmodule

// File: rtl/ctp_tick.sv
module ctp_tick #(
   parameter bit BOTH_OK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cnt_in,
   input  logic both,
   output logic tick
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= cnt_in;
   end

   if (BOTH_OK) begin : g_dual_edge
      assign tick = both ? (cnt_in ^ prev_q) : (cnt_in & ~prev_q);
   end else begin : g_rise_only
      logic unused_both;
      assign unused_both = both;
      assign tick        = cnt_in & ~prev_q;
   end

endmodule

// File: rtl/ctp_counter.sv
module ctp_counter #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr,
   input  logic [W-1:0] cmp,
   output logic [W-1:0] cnt,
   output logic         eq
);

   localparam logic [W-1:0] ONE = W'(1);

   if (W < 2) begin : g_bad_width
      $error("ctp_counter: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + ONE;
   end

   assign eq = (cnt == cmp);

endmodule

// File: rtl/ctp_outctl.sv
module ctp_outctl #(
   parameter int unsigned W       = 8,
   parameter bit          BOTH_OK = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pwm_sel,
   input  logic         oe_lo,
   input  logic         oe_hi,
   input  logic         both_eff,
   input  logic [W-1:0] lo_cnt,
   input  logic [W-1:0] cmp_lo,
   input  logic [W-1:0] hwid,
   input  logic         ev_lo,
   input  logic         ev_hi,
   output logic         out_lo,
   output logic         out_hi,
   output logic         cfg_err
);

   localparam logic [W-1:0] V_ZERO = '0;
   localparam logic [W-1:0] V_ONE  = W'(1);
   localparam logic [W-1:0] V_TOP  = '1;

   logic tgl_lo_q, tgl_hi_q;
   logic bad_rise, bad_both;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgl_lo_q <= 1'b0;
         tgl_hi_q <= 1'b0;
      end else begin
         tgl_lo_q <= oe_lo & (tgl_lo_q ^ ev_lo);
         tgl_hi_q <= oe_hi & (tgl_hi_q ^ ev_hi);
      end
   end

   assign out_lo = oe_lo & (pwm_sel ? (lo_cnt < hwid) : tgl_lo_q);
   assign out_hi = oe_hi & tgl_hi_q;

   assign bad_rise = (cmp_lo == V_ZERO);

   if (BOTH_OK) begin : g_both_check
      assign bad_both = bad_rise | (cmp_lo == V_ONE) | (cmp_lo == V_TOP);
   end else begin : g_rise_check
      assign bad_both = bad_rise;
   end

   assign cfg_err = pwm_sel & (both_eff ? bad_both : bad_rise);

endmodule

// File: rtl/cmp_timer_pair.sv
module cmp_timer_pair
   import ctp_pkg::*;
#(
   parameter int unsigned W            = 8,
   parameter bit          BOTH_EDGE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [W-1:0]      wr_data,
   input  logic              cnt_in,
   output logic              out_lo,
   output logic              out_hi,
   output logic              irq_lo,
   output logic              irq_hi,
   output logic              cfg_err
);

   if (W < CTRL_BITS) begin : g_bad_width
      $error("cmp_timer_pair: W too small for control field");
   end

   logic [W-1:0] cmp_lo, cmp_hi, hwid;
   ctp_ctrl_t    ctrl;
   logic         tick, casc, pwm_sel, both_eff;
   logic         ev_lo, ev_hi;
   logic [W-1:0] cmp_v [NUM_CH];
   logic [W-1:0] cnt_v [NUM_CH];
   logic         eq_v  [NUM_CH];
   logic         inc_v [NUM_CH];
   logic         clr_v [NUM_CH];

   ctp_regs #(.W(W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi), .hwid(hwid),
      .ctrl(ctrl)
   );

   assign casc     = ctrl.cascade;
   assign both_eff = ctrl.both_edges & BOTH_EDGE_EN;
   assign pwm_sel  = (ctrl.mode == MODE_PWM) & ~casc;
   assign cmp_v[0] = cmp_lo;
   assign cmp_v[1] = cmp_hi;

   ctp_tick #(.BOTH_OK(BOTH_EDGE_EN)) u_tick (
      .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .both(both_eff), .tick(tick)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ctp_counter #(.W(W)) u_cnt (
         .clk(clk), .rst_n(rst_n), .inc(inc_v[c]), .clr(clr_v[c]),
         .cmp(cmp_v[c]), .cnt(cnt_v[c]), .eq(eq_v[c])
      );
   end

   always_comb begin
      inc_v[0] = tick;
      clr_v[0] = tick & eq_v[0];
      if (casc) begin
         inc_v[1] = tick & eq_v[0];
         clr_v[1] = tick & eq_v[0] & eq_v[1];
         ev_lo    = 1'b0;
      end else begin
         inc_v[1] = tick;
         clr_v[1] = tick & eq_v[1];
         ev_lo    = clr_v[0];
      end
      ev_hi = clr_v[1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_lo <= 1'b0;
         irq_hi <= 1'b0;
      end else begin
         irq_lo <= ev_lo;
         irq_hi <= ev_hi;
      end
   end

   ctp_outctl #(.W(W), .BOTH_OK(BOTH_EDGE_EN)) u_out (
      .clk(clk), .rst_n(rst_n), .pwm_sel(pwm_sel), .oe_lo(ctrl.oe_lo),
      .oe_hi(ctrl.oe_hi), .both_eff(both_eff), .lo_cnt(cnt_v[0]),
      .cmp_lo(cmp_lo), .hwid(hwid), .ev_lo(ev_lo), .ev_hi(ev_hi),
      .out_lo(out_lo), .out_hi(out_hi), .cfg_err(cfg_err)
   );

   // R1: a low interrupt pulse coincides with the counter sitting at zero
   p_lo_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      irq_lo |-> (cnt_v[0] == '0));

   // R3: no low interrupt follows a cycle spent in cascade
   p_no_lo_irq_casc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_lo |-> !$past(casc));

   // R4: in cascade the high half moves only on a low wrap
   p_casc_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(casc) && (cnt_v[1] != $past(cnt_v[1]))) |-> (cnt_v[0] == '0));

   // R4: joint interrupt leaves both halves cleared
   p_joint_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_hi && $past(casc)) |-> ((cnt_v[0] == '0) && (cnt_v[1] == '0)));

endmodule

// File: tb/cmp_timer_pair_test.sv
module cmp_timer_pair_test;
   timeunit 1ns;
   timeprecision 100ps;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       cnt_in = 1'b0;
   logic       out_lo, out_hi, irq_lo, irq_hi, cfg_err;

   int n_chk = 0;
   int n_fail = 0;
   int lo_irq_in_casc = 0;
   string ph = "R9 reset";

   always #5 clk = ~clk;

   cmp_timer_pair uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cnt_in(cnt_in), .out_lo(out_lo), .out_hi(out_hi),
      .irq_lo(irq_lo), .irq_hi(irq_hi), .cfg_err(cfg_err)
   );

   // ---------------- cycle model built from the requirements ----------------
   logic [7:0] m_cmp0, m_cmp1, m_hw, m_ctl, m_lo, m_hi;
   logic       m_prev, m_irq_lo, m_irq_hi, m_t0, m_t1;

   always @(posedge clk or negedge rst_n) begin : mdl
      logic tk, e_lo, e_hi, both, casc;
      if (!rst_n) begin
         m_cmp0 <= 0; m_cmp1 <= 0; m_hw <= 0; m_ctl <= 0; m_lo <= 0; m_hi <= 0;
         m_prev <= 0; m_irq_lo <= 0; m_irq_hi <= 0; m_t0 <= 0; m_t1 <= 0;
      end else begin
         both = m_ctl[2];
         casc = m_ctl[3];
         tk   = both ? (cnt_in ^ m_prev) : (cnt_in & ~m_prev);
         e_lo = 1'b0;
         e_hi = 1'b0;
         m_prev <= cnt_in;
         if (tk) begin
            if (casc) begin
               if (m_lo == m_cmp0) begin
                  m_lo <= 0;
                  if (m_hi == m_cmp1) begin m_hi <= 0; e_hi = 1'b1; end
                  else m_hi <= m_hi + 8'd1;
               end else m_lo <= m_lo + 8'd1;
            end else begin
               if (m_lo == m_cmp0) begin m_lo <= 0; e_lo = 1'b1; end
               else m_lo <= m_lo + 8'd1;
               if (m_hi == m_cmp1) begin m_hi <= 0; e_hi = 1'b1; end
               else m_hi <= m_hi + 8'd1;
            end
         end
         m_irq_lo <= e_lo;
         m_irq_hi <= e_hi;
         m_t0 <= m_ctl[4] ? (m_t0 ^ e_lo) : 1'b0;
         m_t1 <= m_ctl[5] ? (m_t1 ^ e_hi) : 1'b0;
         if (wr_en) begin
            case (wr_addr)
               2'd0: m_cmp0 <= wr_data;
               2'd1: m_cmp1 <= wr_data;
               2'd2: m_hw   <= wr_data;
               default: m_ctl <= {2'b00, wr_data[5:0]};
            endcase
         end
      end
   end

   function automatic logic exp_pwm();
      return (m_ctl[1:0] == 2'b10) && !m_ctl[3];
   endfunction

   function automatic logic exp_out_lo();
      return m_ctl[4] && (exp_pwm() ? (m_lo < m_hw) : m_t0);
   endfunction

   function automatic logic exp_cfg_err();
      if (!exp_pwm()) return 1'b0;
      if (m_ctl[2]) return (m_cmp0 == 8'h00) || (m_cmp0 == 8'h01) || (m_cmp0 == 8'hFF);
      return m_cmp0 == 8'h00;
   endfunction

   task automatic check(input logic ok, input string req, input logic [7:0] act,
                        input logic [7:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s [%s] at %0t: actual %0h expected %0h", req, ph, $time, act, exp);
      end
   endtask

   task automatic compare();
      if (!rst_n) return;
      check(irq_lo == m_irq_lo, "R1 irq_lo", irq_lo, m_irq_lo);
      check(irq_hi == m_irq_hi, "R4 irq_hi", irq_hi, m_irq_hi);
      check(out_lo == exp_out_lo(), "R5 R8 out_lo", out_lo, exp_out_lo());
      check(out_hi == (m_ctl[5] & m_t1), "R8 out_hi", out_hi, m_ctl[5] & m_t1);
      check(cfg_err == exp_cfg_err(), "R6 cfg_err", cfg_err, exp_cfg_err());
      if (m_ctl[3] && irq_lo) lo_irq_in_casc++;
   endtask

   task automatic cyc(input logic c, input logic we, input logic [1:0] a,
                      input logic [7:0] d);
      @(negedge clk);
      compare();
      cnt_in  = c;
      wr_en   = we;
      wr_addr = a;
      wr_data = d;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      cyc(cnt_in, 1'b1, a, d);
   endtask

   task automatic run_toggle(input int n);
      for (int i = 0; i < n; i++) cyc(~cnt_in, 1'b0, 2'd0, 8'd0);
   endtask

   task automatic run_rand(input int n);
      for (int i = 0; i < n; i++) begin
         logic [1:0] a;
         logic [7:0] d;
         a = 2'($urandom);
         d = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 12);
         if ($urandom % 16 == 0) cyc(1'($urandom), 1'b1, a, d);
         else                    cyc(1'($urandom), 1'b0, 2'd0, 8'd0);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      ph = "watchdog";
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: actual running expected done");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state observed at the ports
      check({out_lo, out_hi, irq_lo, irq_hi, cfg_err} == 5'b0, "R9 reset outputs",
            {3'b0, out_lo, out_hi, irq_lo, irq_hi, cfg_err}, 8'h00);

      ph = "R1 R10 interval";
      wr(2'd0, 8'd3); wr(2'd1, 8'd5); wr(2'd3, 8'h30);
      run_toggle(60);

      ph = "R2 both edges";
      wr(2'd3, 8'h34);
      run_toggle(40);

      ph = "R3 R4 cascade";
      wr(2'd0, 8'd2); wr(2'd1, 8'd2); wr(2'd3, 8'h38);
      run_toggle(80);
      wr(2'd3, 8'h3C);
      run_toggle(50);
      check(lo_irq_in_casc == 0, "R3 lo irq in cascade", 8'(lo_irq_in_casc), 8'd0);

      ph = "R5 PWM";
      wr(2'd0, 8'd9); wr(2'd2, 8'd4); wr(2'd3, 8'h12);
      run_toggle(60);
      wr(2'd2, 8'd0);  run_toggle(30);
      wr(2'd2, 8'd12); run_toggle(30);
      wr(2'd3, 8'h16); wr(2'd2, 8'd3); run_toggle(40);

      ph = "R6 illegal values";
      wr(2'd3, 8'h12);
      wr(2'd0, 8'h00); wr(2'd0, 8'h01); wr(2'd0, 8'hFF); wr(2'd0, 8'h02);
      wr(2'd3, 8'h16);
      wr(2'd0, 8'h01); wr(2'd0, 8'hFF); wr(2'd0, 8'h00); wr(2'd0, 8'h02);
      wr(2'd3, 8'h1A);
      wr(2'd0, 8'h00);
      run_toggle(4);

      ph = "R7 output disabled";
      wr(2'd0, 8'd6); wr(2'd2, 8'd3); wr(2'd3, 8'h12);
      run_toggle(20);
      wr(2'd3, 8'h02);
      run_toggle(5);
      wr(2'd0, 8'd2);
      run_toggle(5);
      wr(2'd0, 8'd7);
      run_toggle(10);
      wr(2'd3, 8'h00);
      run_toggle(20);
      wr(2'd3, 8'h30);
      run_toggle(10);

      ph = "R10 random mix";
      run_rand(4000);

      cyc(cnt_in, 1'b0, 2'd0, 8'd0);
      finish_run();
   end

endmodule